// File: doc/BRIEF.md
# Cache Burst Address Sequencer

This block captures a start address for a synchronous cache memory and then walks the two lowest address bits through a four-beat burst. Two active-low strobes can start a burst. The controller-side strobe loads on its own. The processor-side strobe loads only while chip enable is low. After a load, each clock edge with the active-low step input low moves the burst one beat forward. A static order input selects the beat order: with the input low, the low bits count up modulo four from the start offset; with it high, the start offset is XORed with the beat number.

The sequencer drives the current memory address from registered state, so a load or a step shows on the address output in the cycle after the edge that caused it. A valid flag goes high with the first load and stays high until a synchronous reset.

Top module: `burst_addr_seq`

## Requirements
- R1: A clock edge with `ctl_stb_n` low loads `ld_addr`, whatever `ce_n` is. After that edge, `mem_addr` equals `ld_addr` and `addr_valid` is 1.
- R2: `cpu_stb_n` low loads `ld_addr` only when `ce_n` is also low on the same edge. With `ce_n` high, the processor strobe has no effect on `mem_addr` or `addr_valid`.
- R3: When no load happens and `addr_valid` is 1, a step input `step_n` low on an edge advances the beat count by one. With `step_n` high, `mem_addr` holds.
- R4: With `order_il` = 0 (linear), bits [1:0] of `mem_addr` equal (start offset + beat) mod 4.
- R5: With `order_il` = 1 (interleaved), bits [1:0] of `mem_addr` equal start offset XOR beat.
- R6: Bits [ADDR_W-1:2] of `mem_addr` keep the loaded value for the whole burst. After the fourth beat the beat count wraps to 0, which returns the start offset.
- R7: A load on the same edge as `step_n` low, or with both strobes low, takes priority. The burst restarts at beat 0 with the new address.
- R8: A synchronous reset (`rst` high) makes `addr_valid` 0 and `mem_addr` 0. While `addr_valid` is 0, `step_n` low does not move the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, qualified by `ce_n` |
| ce_n | input | 1 | Chip enable, active low |
| step_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| ld_addr | input | ADDR_W | Start address captured on a load |
| mem_addr | output | ADDR_W | Current burst address |
| addr_valid | output | 1 | High once an address has been loaded since reset |

## Verification
The bench starts bursts at nonzero offsets in both orders, so an adder used where the XOR belongs, or the reverse, gives a wrong low-bit sequence within two beats. It sends the processor strobe with chip enable high. A design that skips that gate then replaces the address. It also sends a load together with a step, and both strobes together. A design that lets the step win, or that does not clear the beat count, shows an offset one beat ahead. The bench runs a burst past its fourth beat to catch a counter that saturates, or that carries into the upper bits. It also steps with no address loaded after reset, which shows a counter that moves without a valid address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic  valid;
        beat_t beat;
    } burst_state_t;

    function automatic beat_t beat_offset(input order_e ord, input beat_t start, input beat_t beat);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ beat;
        else                       r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/strobe_qual.sv
module strobe_qual (
    input  logic ctl_stb_n,
    input  logic cpu_stb_n,
    input  logic ce_n,
    output logic load
);
    logic ctl_hit;
    logic cpu_hit;

    always_comb begin
        ctl_hit = !ctl_stb_n;
        cpu_hit = !cpu_stb_n && !ce_n;
        load    = ctl_hit || cpu_hit;
    end
endmodule

// File: rtl/beat_counter.sv
module beat_counter
    import burst_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step_n,
    output burst_state_t state
);
    burst_state_t nxt;

    always_comb begin
        nxt = state;
        if (load) begin
            nxt.valid = 1'b1;
            nxt.beat  = '0;
        end else if (state.valid && !step_n) begin
            nxt.beat = state.beat + beat_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_n && state.valid) |=> (state.beat == beat_t'($past(state.beat) + beat_t'(1)))); // R3
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
        (!load && step_n) |=> $stable(state.beat)); // R3
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        load |=> (state.beat == '0 && state.valid)); // R7
    AST_VALID_KEPT: assert property (@(posedge clk) disable iff (rst)
        state.valid |=> state.valid); // R8
    AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!load && !state.valid) |=> (state.beat == '0)); // R8
endmodule

// File: rtl/addr_compose.sv
module addr_compose
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  order_e            ord,
    output logic [ADDR_W-1:0] addr
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    always_comb begin
        addr = {base[ADDR_W-1:BEAT_W], beat_offset(ord, base[BEAT_W-1:0], beat)};
    end

    initial begin
        AST_WIDTH_OK: assert (UPPER_W > 0); // R6
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_stb_n,
    input  logic              cpu_stb_n,
    input  logic              ce_n,
    input  logic              step_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              addr_valid
);
    logic              load;
    logic [ADDR_W-1:0] base_q;
    burst_state_t      st;
    order_e            ord;

    assign ord = order_e'(order_il);

    strobe_qual u_qual (
        .ctl_stb_n (ctl_stb_n),
        .cpu_stb_n (cpu_stb_n),
        .ce_n      (ce_n),
        .load      (load)
    );

    beat_counter u_beat (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step_n (step_n),
        .state  (st)
    );

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= ld_addr;
    end

    addr_compose #(.ADDR_W(ADDR_W)) u_comp (
        .base (base_q),
        .beat (st.beat),
        .ord  (ord),
        .addr (mem_addr)
    );

    assign addr_valid = st.valid;

    AST_LOAD_SEEN: assert property (@(posedge clk) disable iff (rst)
        (!ctl_stb_n) |=> (mem_addr == $past(ld_addr) && addr_valid)); // R1
    AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
        (ctl_stb_n && ce_n && step_n) |=> ($stable(mem_addr) && $stable(addr_valid))); // R2
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (ctl_stb_n && (cpu_stb_n || ce_n)) |=> $stable(mem_addr[ADDR_W-1:BEAT_W])); // R6
    AST_ORDER_STATIC: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && ctl_stb_n && (cpu_stb_n || ce_n)) |=> $stable(order_il)); // R4
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int AW = 17;
    localparam int VW = 5 + AW + AW + 1;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctl_stb_n, cpu_stb_n, ce_n, step_n, order_il;
    logic [AW-1:0] ld_addr;
    logic [AW-1:0] mem_addr;
    logic          addr_valid;

    int applied = 0;
    int bad     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ctl_stb_n(ctl_stb_n), .cpu_stb_n(cpu_stb_n),
        .ce_n(ce_n), .step_n(step_n), .order_il(order_il), .ld_addr(ld_addr),
        .mem_addr(mem_addr), .addr_valid(addr_valid)
    );

    // {ctl_n, cpu_n, ce_n, step_n, order, ld_addr, expected addr, expected valid}
    localparam logic [VW-1:0] VEC [NV] = '{
        {5'b01110, 17'h00102, 17'h00102, 1'b1},  // R1 controller load, offset 2
        {5'b11100, 17'h00000, 17'h00103, 1'b1},  // R4 linear beat 1
        {5'b11100, 17'h00000, 17'h00100, 1'b1},  // R4 linear beat 2 wraps low bits
        {5'b11110, 17'h00000, 17'h00100, 1'b1},  // R3 hold
        {5'b11100, 17'h00000, 17'h00101, 1'b1},  // R4 linear beat 3
        {5'b11100, 17'h00000, 17'h00102, 1'b1},  // R6 beat count wraps to 0
        {5'b10110, 17'h1F0F0, 17'h00102, 1'b1},  // R2 cpu strobe without chip enable
        {5'b10000, 17'h1F0F1, 17'h1F0F1, 1'b1},  // R7 cpu load beats step
        {5'b01111, 17'h0ABC6, 17'h0ABC6, 1'b1},  // R1 load, interleaved
        {5'b11101, 17'h00000, 17'h0ABC7, 1'b1},  // R5 2^1
        {5'b11101, 17'h00000, 17'h0ABC4, 1'b1},  // R5 2^2
        {5'b11101, 17'h00000, 17'h0ABC5, 1'b1},  // R5 2^3
        {5'b00001, 17'h00011, 17'h00011, 1'b1},  // R7 both strobes with step
        {5'b11101, 17'h00000, 17'h00010, 1'b1},  // R5 1^1
        {5'b11101, 17'h00000, 17'h00013, 1'b1},  // R5 1^2
        {5'b11101, 17'h00000, 17'h00012, 1'b1}   // R6 1^3, upper bits fixed
    };

    task automatic chk(input string req, input logic [AW-1:0] ea, input logic ev);
        applied++;
        if (mem_addr !== ea || addr_valid !== ev) begin
            bad++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     req, mem_addr, addr_valid, ea, ev);
        end
    endtask

    task automatic drive(input logic c, input logic p, input logic e, input logic s,
                         input logic o, input logic [AW-1:0] a);
        @(negedge clk);
        ctl_stb_n = c; cpu_stb_n = p; ce_n = e; step_n = s; order_il = o; ld_addr = a;
        @(posedge clk);
        #5;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            applied++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctl_stb_n = 1'b1; cpu_stb_n = 1'b1; ce_n = 1'b1;
        step_n = 1'b1; order_il = 1'b0; ld_addr = '0;
        repeat (3) @(posedge clk);
        #5;
        chk("R8 reset state", '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            drive(v[VW-1], v[VW-2], v[VW-3], v[VW-4], v[VW-5],
                  v[2*AW:AW+1]);
            chk($sformatf("vector %0d", i), v[AW:1], v[0]);
        end

        // R8: reset in the middle of a burst
        @(negedge clk);
        rst = 1'b1; step_n = 1'b0; ctl_stb_n = 1'b1; cpu_stb_n = 1'b1;
        @(posedge clk); #5;
        chk("R8 reset mid-burst", '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R8: stepping with nothing loaded
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 17'h12345);
        chk("R8 step without load", '0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 17'h12345);
        chk("R8 step without load again", '0, 1'b0);

        // R2: processor strobe with chip enable high, nothing loaded
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 17'h00A5A);
        chk("R2 gated strobe ignored", '0, 1'b0);

        // R2: processor strobe with chip enable low loads
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 17'h00A5B);
        chk("R2 qualified cpu load", 17'h00A5B, 1'b1);

        // R4: linear from offset 3 wraps through 0
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        chk("R4 linear 3+1", 17'h00A58, 1'b1);

        // R1: controller strobe loads with chip enable high
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 17'h10007);
        chk("R1 controller load ce high", 17'h10007, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule